// File: doc/BRIEF.md
# Interrupt Source Routing Matrix

This block steers a set of peripheral interrupt request lines onto the 64 request inputs of an interrupt controller. Each peripheral source owns one 6-bit routing register. The value in that register is the full controller entry index that the source should drive. It is not the CPU line number. An external CPU line n (legal n = 1..31) therefore corresponds to the stored value n + 16, so useful values run from 17 to 47. A stored value of zero disconnects the source.

Software programs the routing registers through a simple word-wide write/read port. The port is addressed in bytes, and each source's register sits at byte offset 4 × source number. The controller side sees one request bit per entry. Each bit is the OR of every source currently routed to that entry, formed without any register in the path, so a change on a source reaches its entry in the same cycle.

Top module: `irq_route_matrix`

## Requirements
- R1: While `rst` is high at a rising clock edge, every routing register is cleared to 0. After reset, every source reads back 0 and no `entry_req` bit is set, whatever `irq_src` is.
- R2: A write keeps only bits [5:0] of `cfg_wdata`. A later read of that register returns the kept value in bits [5:0] and zero in bits [31:6].
- R3: A source whose routing register holds 0 drives no `entry_req` bit.
- R4: Bit k of `entry_req` is high exactly when at least one source with routing value k has its `irq_src` bit high. Several sources may share one entry.
- R5: The routing from `irq_src` to `entry_req` is combinational. A change on `irq_src` is visible on `entry_req` in the same cycle, before the next clock edge.
- R6: Source s's register is selected by a `cfg_addr` byte offset of 4 × s. The two low address bits are ignored. An offset whose word index is NUM_SRC or above selects nothing: a write to it changes no register, and a read of it returns 0.
- R7: `entry_req[0]` is never set.
- R8: A write changes only the register it addresses. Every other source keeps its value.
- R9: `cfg_rdata` is registered. The value present after a rising edge reflects the register selected by `cfg_addr` at that edge, as it stood before any write at that same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_src | input | NUM_SRC | Peripheral interrupt requests, one per source |
| cfg_we | input | 1 | Write strobe for the routing registers |
| cfg_addr | input | ADDR_W | Byte address; word index selects the source |
| cfg_wdata | input | 32 | Write data; only bits [5:0] are kept |
| cfg_rdata | output | 32 | Registered read data for the addressed source |
| entry_req | output | 64 | Request lines toward the controller, one per entry |

## Verification
On every cycle, the assertions check four things: entry 0 stays quiet, no more entries are raised than there are active sources, a silent source vector gives a silent output vector, and reads of out-of-range offsets return zero. They also check that a reset cycle leaves the outputs clear. Only the bench scenarios can show the rest, because each depends on a history of writes. This covers the exact entry that a given mapping lights, the sharing of one entry by several sources, the masking of write data to six bits, and the fact that one write leaves the other registers intact. The bench judges these against a shadow copy of the routing table that it keeps from its own writes.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  // Width of one routing value; also fixes the controller entry count.
  localparam int MAP_W = 6;
  // Width of the software data bus.
  localparam int REG_W = 32;
  // External CPU line n is stored as entry n + EXT_LINE_OFFSET.
  localparam int EXT_LINE_OFFSET = 16;

  typedef logic [MAP_W-1:0] map_idx_t;
endpackage

// File: rtl/irq_map_decode.sv
module irq_map_decode #(
  parameter int NUM_SRC = 20,
  parameter int ADDR_W  = 7
) (
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  output logic [NUM_SRC-1:0] wsel,
  output logic [ADDR_W-3:0] rd_idx,
  output logic              rd_hit
);
  localparam int IDX_W = ADDR_W - 2;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_SRC - 1);

  logic [IDX_W-1:0] word_idx;
  logic             unused_lo;

  // Registers are word spaced: drop the byte-in-word bits.
  assign word_idx  = cfg_addr[ADDR_W-1:2];
  assign unused_lo = ^cfg_addr[1:0];
  assign rd_idx    = word_idx;
  assign rd_hit    = (word_idx <= LAST_IDX);

  // One-hot write select; out-of-range indices match no source.
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_wsel
    assign wsel[g] = cfg_we && (word_idx == IDX_W'(g));
  end
endmodule

// File: rtl/irq_map_regs.sv
module irq_map_regs
  import irq_route_pkg::*;
#(
  parameter int NUM_SRC = 20,
  parameter int IDX_W   = 5
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_SRC-1:0]       wsel,
  input  map_idx_t                 wr_val,
  input  logic [IDX_W-1:0]         rd_idx,
  input  logic                     rd_hit,
  output logic [NUM_SRC*MAP_W-1:0] map_flat,
  output logic [REG_W-1:0]         rdata
);
  map_idx_t             map_q [NUM_SRC];
  map_idx_t             rd_sel;
  logic [REG_W-1:0]     rdata_q;

  // Routing table: every source starts disconnected.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_SRC; i++) map_q[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_SRC; i++)
        if (wsel[i]) map_q[i] <= wr_val;
    end
  end

  // Read mux over the table, guarded against indices past the last source.
  always_comb begin
    rd_sel = '0;
    for (int i = 0; i < NUM_SRC; i++)
      if (rd_idx == IDX_W'(i)) rd_sel = map_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= '0;
    else if (rd_hit) rdata_q <= {{(REG_W-MAP_W){1'b0}}, rd_sel};
    else             rdata_q <= '0;
  end

  assign rdata = rdata_q;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_flat
    assign map_flat[g*MAP_W +: MAP_W] = map_q[g];
  end
endmodule

// File: rtl/irq_route_fanin.sv
module irq_route_fanin
  import irq_route_pkg::*;
#(
  parameter int NUM_SRC   = 20,
  parameter int NUM_ENTRY = 64
) (
  input  logic [NUM_SRC-1:0]       irq_src,
  input  logic [NUM_SRC*MAP_W-1:0] map_flat,
  output logic [NUM_ENTRY-1:0]     entry_req
);
  for (genvar k = 0; k < NUM_ENTRY; k++) begin : g_entry
    if (k == 0) begin : g_park
      // Value 0 means "unmapped", so entry 0 has no driver.
      assign entry_req[k] = 1'b0;
    end else begin : g_or
      logic hit;
      always_comb begin
        hit = 1'b0;
        for (int s = 0; s < NUM_SRC; s++)
          if (irq_src[s] && (map_flat[s*MAP_W +: MAP_W] == MAP_W'(k)))
            hit = 1'b1;
      end
      assign entry_req[k] = hit;
    end
  end
endmodule

// File: rtl/irq_route_matrix.sv
module irq_route_matrix
  import irq_route_pkg::*;
#(
  parameter int NUM_SRC = 20,
  localparam int ADDR_W    = $clog2(NUM_SRC) + 2,
  localparam int NUM_ENTRY = 2 ** MAP_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_SRC-1:0]   irq_src,
  input  logic                 cfg_we,
  input  logic [ADDR_W-1:0]    cfg_addr,
  input  logic [REG_W-1:0]     cfg_wdata,
  output logic [REG_W-1:0]     cfg_rdata,
  output logic [NUM_ENTRY-1:0] entry_req
);
  localparam int IDX_W = ADDR_W - 2;

  logic [NUM_SRC-1:0]       wsel;
  logic [IDX_W-1:0]         rd_idx;
  logic                     rd_hit;
  logic [NUM_SRC*MAP_W-1:0] map_flat;
  map_idx_t                 wr_val;
  logic                     unused_wdata;

  // Only the six index bits are stored.
  assign wr_val       = cfg_wdata[MAP_W-1:0];
  assign unused_wdata = ^cfg_wdata[REG_W-1:MAP_W];

  irq_map_decode #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_dec (
    .cfg_we  (cfg_we),
    .cfg_addr(cfg_addr),
    .wsel    (wsel),
    .rd_idx  (rd_idx),
    .rd_hit  (rd_hit)
  );

  irq_map_regs #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wsel    (wsel),
    .wr_val  (wr_val),
    .rd_idx  (rd_idx),
    .rd_hit  (rd_hit),
    .map_flat(map_flat),
    .rdata   (cfg_rdata)
  );

  irq_route_fanin #(.NUM_SRC(NUM_SRC), .NUM_ENTRY(NUM_ENTRY)) u_fanin (
    .irq_src  (irq_src),
    .map_flat (map_flat),
    .entry_req(entry_req)
  );
endmodule

// File: rtl/irq_route_matrix_chk.sv
module irq_route_matrix_chk #(
  parameter int NUM_SRC   = 20,
  parameter int ADDR_W    = 7,
  parameter int NUM_ENTRY = 64
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NUM_SRC-1:0]   irq_src,
  input logic [ADDR_W-1:0]    cfg_addr,
  input logic [31:0]          cfg_rdata,
  input logic [NUM_ENTRY-1:0] entry_req
);
  localparam int IDX_W = ADDR_W - 2;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_SRC - 1);

  logic out_of_range;
  assign out_of_range = (cfg_addr[ADDR_W-1:2] > LAST_IDX) && (^cfg_addr[1:0] | 1'b1);

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (entry_req == '0));

  // R7
  entry0_idle_chk: assert property (@(posedge clk) disable iff (rst) !entry_req[0]);

  // R4
  no_orphan_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(entry_req) <= $countones(irq_src));

  // R3
  silent_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_src == '0) |-> (entry_req == '0));

  // R6
  oob_read_chk: assert property (@(posedge clk) disable iff (rst)
    out_of_range |=> (cfg_rdata == 32'h0));

  // R2
  upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_rdata[31:6] == '0);
endmodule

bind irq_route_matrix irq_route_matrix_chk #(
  .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .NUM_ENTRY(NUM_ENTRY)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .irq_src  (irq_src),
  .cfg_addr (cfg_addr),
  .cfg_rdata(cfg_rdata),
  .entry_req(entry_req)
);

// File: tb/tb_irq_route_matrix.sv
`timescale 1ns/1ps
module tb_irq_route_matrix;
  localparam int NSRC   = 20;
  localparam int AW     = $clog2(NSRC) + 2;
  localparam int NENT   = 64;
  localparam int NVEC   = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [NSRC-1:0]  irq_src = '1;
  logic             cfg_we = 1'b0;
  logic [AW-1:0]    cfg_addr = '0;
  logic [31:0]      cfg_wdata = '0;
  logic [31:0]      cfg_rdata;
  logic [NENT-1:0]  entry_req;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;
  logic [5:0] shadow [NSRC];

  always #2.5 clk = ~clk;

  irq_route_matrix #(.NUM_SRC(NSRC)) dut (
    .clk(clk), .rst(rst), .irq_src(irq_src), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .entry_req(entry_req)
  );

  // Vector: {source[4:0], write data[31:0], expected readback[5:0]}
  localparam logic [42:0] VEC [NVEC] = '{
    {5'd0,  32'h0000_0011, 6'd17},
    {5'd1,  32'hFFFF_FFD2, 6'd18},
    {5'd5,  32'h0000_002F, 6'd47},
    {5'd19, 32'h8000_0020, 6'd32},
    {5'd7,  32'h0000_0040, 6'd0},
    {5'd12, 32'h0000_003F, 6'd63},
    {5'd3,  32'h1234_5619, 6'd25},
    {5'd19, 32'h0000_0000, 6'd0}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int word, input logic [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = AW'(word * 4); cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input int word, output logic [31:0] data);
    @(negedge clk);
    cfg_addr = AW'(word * 4);
    @(negedge clk);
    data = cfg_rdata;
  endtask

  function automatic logic [NENT-1:0] model(input logic [NSRC-1:0] pat);
    logic [NENT-1:0] r = '0;
    for (int s = 0; s < NSRC; s++)
      if (pat[s] && shadow[s] != 6'd0) r[shadow[s]] = 1'b1;
    return r;
  endfunction

  task automatic route_check(input string req, input logic [NSRC-1:0] pat);
    @(negedge clk);
    irq_src = pat;
    #1;  // same cycle, no clock edge in between
    check(req, 64'(entry_req), 64'(model(pat)));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    for (int i = 0; i < NSRC; i++) shadow[i] = 6'd0;

    // R1: reset clears outputs even with every source active
    repeat (3) @(negedge clk);
    check("R1 entries in reset", 64'(entry_req), 64'h0);
    check("R1 rdata in reset", 64'(cfg_rdata), 64'h0);
    rst = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      rd(i, d);
      check("R1 map reads zero", 64'(d), 64'h0);
    end
    route_check("R1 R3 all unmapped, all active", '1);

    // R2 R6: table walk of writes with masked readback
    for (int v = 0; v < NVEC; v++) begin
      int src = int'(VEC[v][42:38]);
      wr(src, VEC[v][37:6]);
      shadow[src] = VEC[v][5:0];
      rd(src, d);
      check("R2 R6 readback", 64'(d), 64'(VEC[v][5:0]));
    end

    // R8: every register holds what the shadow says
    for (int i = 0; i < NSRC; i++) begin
      rd(i, d);
      check("R8 no cross-write", 64'(d), 64'(shadow[i]));
    end

    // R6: out-of-range writes and reads
    wr(25, 32'h0000_0014);
    rd(25, d);
    check("R6 out-of-range read", 64'(d), 64'h0);
    for (int i = 0; i < NSRC; i++) begin
      rd(i, d);
      check("R6 out-of-range write ignored", 64'(d), 64'(shadow[i]));
    end

    // R9: read and write at the same edge returns the old value
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = AW'(2 * 4); cfg_wdata = 32'h0000_0015;
    @(negedge clk);
    cfg_we = 1'b0;
    check("R9 read at write edge gives old value", 64'(cfg_rdata), 64'(shadow[2]));
    shadow[2] = 6'd21;
    @(negedge clk);
    check("R9 next read gives new value", 64'(cfg_rdata), 64'd21);

    // R4: shared entry
    wr(2, 32'd30); shadow[2] = 6'd30;
    wr(8, 32'd30); shadow[8] = 6'd30;
    route_check("R4 R5 shared entry via src 8", NSRC'(1) << 8);
    check("R4 entry 30 set", 64'(entry_req[30]), 64'd1);
    route_check("R4 shared entry via src 2", NSRC'(1) << 2);
    route_check("R4 shared entry both", (NSRC'(1) << 2) | (NSRC'(1) << 8));
    route_check("R4 R3 src 7 unmapped alone", NSRC'(1) << 7);
    check("R7 entry 0 quiet", 64'(entry_req[0]), 64'd0);

    // R3: unmap by writing zero
    wr(8, 32'd0); shadow[8] = 6'd0;
    route_check("R3 unmapped source silent", NSRC'(1) << 8);
    check("R3 entry 30 clear", 64'(entry_req[30]), 64'd0);

    // R4 R5: random mappings and source patterns
    for (int it = 0; it < 60; it++) begin
      int s = int'($urandom_range(NSRC - 1, 0));
      int v = ($urandom_range(4, 0) == 0) ? 0 : int'($urandom_range(47, 17));
      wr(s, 32'(v));
      shadow[s] = 6'(v);
      route_check("R4 R5 random pattern", NSRC'($urandom));
    end
    route_check("R4 R7 all sources active", '1);
    route_check("R3 no sources active", '0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule